// File: doc/BRIEF.md
# Dual-Register Phase Accumulator

This block is the frequency-control front end of a direct digital synthesizer. It keeps a running 32-bit phase value that grows by a programmable step on every clock and wraps around freely. The output frequency is the step multiplied by the clock rate and divided by 2^32.

Two step registers are held, called slot A and slot B. Software writes either of them through a simple write port. A one-bit tune input chooses which slot drives the adder. Changing the choice or rewriting a slot never touches the stored phase; only later steps differ. This lets the output frequency hop on a single clock with no phase jump.

Any step word at or above 2^31 is clamped on write, so the output stays below half the clock rate. The top 12 phase bits are presented as the address for a downstream phase-to-amplitude converter. The lower bits are dropped.

Top module: `dds_phase_front`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the phase and both step registers to zero.
- R2: At every rising edge out of reset, phase_out becomes the previous phase_out plus the currently selected step, modulo 2^32.
- R3: tune_slot = 0 selects slot A and tune_slot = 1 selects slot B. The value present at an edge decides the step added at that same edge.
- R4: With wr_en high, wr_slot = 0 writes slot A and wr_slot = 1 writes slot B. The written word is first added at the edge after the write edge; the write edge itself still adds the old value.
- R5: A written word with bit 31 set is stored as 0x7FFF_FFFF. Any other word is stored unchanged.
- R6: The carry out of bit 31 is discarded, so the phase wraps from near 2^32 to a small value.
- R7: Switching tune_slot or writing a slot leaves the stored phase untouched. The next phase is always the old phase plus exactly one step.
- R8: conv_addr always equals phase_out bits 31 down to 20.
- R9: When reset and a write fall on the same edge, reset wins and the slot stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for a step register |
| wr_slot | input | 1 | Target of the write: 0 slot A, 1 slot B |
| wr_data | input | 32 | Step word to store (clamped if bit 31 is set) |
| tune_slot | input | 1 | Step selection: 0 slot A, 1 slot B |
| phase_out | output | 32 | Accumulated phase |
| conv_addr | output | 12 | Top phase bits for the amplitude converter |

## Verification
Two events can fall on the same edge: a write to a slot, and the adder's use of that same slot, possibly at the very edge where the selection switches to it. The bench provokes this by writing slot B while moving tune_slot from A to B. It expects the phase to advance by the old B value at that edge and by the new B value one edge later. The same collision is also judged between reset and a write: after reset is released, no phase movement is expected.

// File: rtl/dds_front_pkg.sv
`timescale 1ns/1ps
package dds_front_pkg;
  localparam int DEF_PHASE_W = 32;
  localparam int DEF_ADDR_W  = 12;
  localparam int NUM_SLOTS   = 2;

  typedef enum logic {
    SLOT_A = 1'b0,
    SLOT_B = 1'b1
  } slot_e;
endpackage

// File: rtl/dds_step_bank.sv
`timescale 1ns/1ps
module dds_step_bank #(
  parameter int W     = 32,
  parameter int SLOTS = 2,
  parameter int IDX_W = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_slot,
  input  logic [W-1:0]       wr_data,
  output logic [SLOTS*W-1:0] slots_flat
);
  localparam logic [W-1:0] STEP_MAX = {1'b0, {(W-1){1'b1}}};

  function automatic logic [W-1:0] limit_step(input logic [W-1:0] word);
    limit_step = word[W-1] ? STEP_MAX : word;
  endfunction

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [W-1:0] step_q;
    always_ff @(posedge clk) begin
      if (rst)
        step_q <= '0;
      else if (wr_en && (wr_slot == IDX_W'(g)))
        step_q <= limit_step(wr_data);
    end
    assign slots_flat[g*W +: W] = step_q;
  end
endmodule

// File: rtl/dds_step_select.sv
`timescale 1ns/1ps
module dds_step_select #(
  parameter int W     = 32,
  parameter int SLOTS = 2,
  parameter int IDX_W = 1
) (
  input  logic [SLOTS*W-1:0] slots_flat,
  input  logic [IDX_W-1:0]   pick,
  output logic [W-1:0]       step
);
  always_comb begin
    step = '0;
    for (int i = 0; i < SLOTS; i++)
      if (pick == IDX_W'(i)) step = slots_flat[i*W +: W];
  end
endmodule

// File: rtl/dds_phase_core.sv
`timescale 1ns/1ps
module dds_phase_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] step,
  output logic [W-1:0] phase_q
);
  function automatic logic [W-1:0] advance(input logic [W-1:0] cur,
                                           input logic [W-1:0] inc);
    logic [W:0] wide;
    wide    = {1'b0, cur} + {1'b0, inc};
    advance = wide[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= advance(phase_q, step);
  end
endmodule

// File: rtl/dds_phase_front.sv
`timescale 1ns/1ps
module dds_phase_front #(
  parameter int PHASE_W = dds_front_pkg::DEF_PHASE_W,
  parameter int ADDR_W  = dds_front_pkg::DEF_ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_slot,
  input  logic [PHASE_W-1:0] wr_data,
  input  logic               tune_slot,
  output logic [PHASE_W-1:0] phase_out,
  output logic [ADDR_W-1:0]  conv_addr
);
  localparam int SLOTS = dds_front_pkg::NUM_SLOTS;
  localparam int IDX_W = 1;

  logic [SLOTS*PHASE_W-1:0] slots_flat;
  logic [PHASE_W-1:0]       active_step;
  logic                     write_fire;

  assign write_fire = wr_en & ~rst;

  dds_step_bank #(.W(PHASE_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot),
    .wr_data    (wr_data),
    .slots_flat (slots_flat)
  );

  dds_step_select #(.W(PHASE_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_sel (
    .slots_flat (slots_flat),
    .pick       (tune_slot),
    .step       (active_step)
  );

  dds_phase_core #(.W(PHASE_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .step    (active_step),
    .phase_q (phase_out)
  );

  assign conv_addr = phase_out[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/dds_phase_front_chk.sv
`timescale 1ns/1ps
module dds_phase_front_chk #(
  parameter int W  = 32,
  parameter int AW = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           write_fire,
  input logic           wr_slot,
  input logic [W-1:0]   wr_data,
  input logic           tune_slot,
  input logic [2*W-1:0] slots_flat,
  input logic [W-1:0]   active_step,
  input logic [W-1:0]   phase_out,
  input logic [AW-1:0]  conv_addr
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (phase_out == '0 && slots_flat == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (phase_out - $past(phase_out)) == $past(active_step));

  assert_sel_R3: assert property (@(posedge clk) disable iff (rst)
    active_step == (tune_slot ? slots_flat[2*W-1:W] : slots_flat[W-1:0]));

  assert_write_R4: assert property (@(posedge clk) disable iff (rst)
    (write_fire && !wr_slot && !wr_data[W-1]) |=> slots_flat[W-1:0] == $past(wr_data));

  assert_bound_R5: assert property (@(posedge clk) disable iff (rst)
    !slots_flat[W-1] && !slots_flat[2*W-1]);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !write_fire |=> $stable(slots_flat));

  assert_addr_R8: assert property (@(posedge clk) disable iff (rst)
    conv_addr == phase_out[W-1 -: AW]);
endmodule

bind dds_phase_front dds_phase_front_chk #(.W(PHASE_W), .AW(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .write_fire  (write_fire),
  .wr_slot     (wr_slot),
  .wr_data     (wr_data),
  .tune_slot   (tune_slot),
  .slots_flat  (slots_flat),
  .active_step (active_step),
  .phase_out   (phase_out),
  .conv_addr   (conv_addr)
);

// File: tb/tb_dds_phase_front.sv
`timescale 1ns/1ps
module tb_dds_phase_front;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic        wr_slot = 0;
  logic [31:0] wr_data = '0;
  logic        tune_slot = 0;
  logic [31:0] phase_out;
  logic [11:0] conv_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_phase;
  logic [31:0] m_step [2];

  always #10 clk = ~clk;

  dds_phase_front dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(wr_data), .tune_slot(tune_slot),
    .phase_out(phase_out), .conv_addr(conv_addr)
  );

  // {wr_en, wr_slot, tune_slot, wr_data}
  localparam logic [34:0] VEC [12] = '{
    {1'b1, 1'b0, 1'b0, 32'h0100_0000},
    {1'b1, 1'b1, 1'b0, 32'h0030_0000},
    {1'b0, 1'b0, 1'b0, 32'h0},
    {1'b0, 1'b0, 1'b1, 32'h0},
    {1'b0, 1'b0, 1'b1, 32'h0},
    {1'b1, 1'b0, 1'b1, 32'h0000_1234},
    {1'b0, 1'b0, 1'b0, 32'h0},
    {1'b1, 1'b1, 1'b0, 32'h4000_0000},
    {1'b0, 1'b0, 1'b1, 32'h0},
    {1'b0, 1'b0, 1'b1, 32'h0},
    {1'b1, 1'b0, 1'b0, 32'h8000_0001},
    {1'b0, 1'b0, 1'b0, 32'h0}
  };

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] clamp(input logic [31:0] w);
    return (w >= 32'h8000_0000) ? 32'h7FFF_FFFF : w;
  endfunction

  // Drive one cycle, update the reference, then sample 1 ns after the edge.
  task automatic tick(input logic we, input logic ws, input logic ts,
                      input logic [31:0] d, input logic do_rst);
    wr_en = we; wr_slot = ws; tune_slot = ts; wr_data = d; rst = do_rst;
    @(posedge clk);
    if (do_rst) begin
      m_phase = '0; m_step[0] = '0; m_step[1] = '0;
    end else begin
      m_phase = m_phase + m_step[ts];
      if (we) m_step[ws] = clamp(d);
    end
    #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_phase = 'x; m_step[0] = 'x; m_step[1] = 'x;
    // R1: reset state
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
    check32(phase_out, 32'h0, "R1 phase after reset");
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    tick(1'b0, 1'b0, 1'b1, 32'h0, 1'b0);
    check32(phase_out, 32'h0, "R1 steps zero after reset");

    // Vector walk: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < 12; i++) begin
      tick(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:0], 1'b0);
      check32(phase_out, m_phase, $sformatf("R2/R3/R4 vector %0d", i));
      check32({20'h0, conv_addr}, {20'h0, m_phase[31:20]}, $sformatf("R8 vector %0d", i));
    end

    // R5 + R6: clamp and wrap with literal values
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0);
    check32(phase_out, 32'h0, "R4 write edge uses old step");
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    check32(phase_out, 32'h7FFF_FFFF, "R5 clamped step");
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    check32(phase_out, 32'hFFFF_FFFE, "R5 second step");
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    check32(phase_out, 32'h7FFF_FFFD, "R6 wrap discards carry");
    check32({20'h0, conv_addr}, 32'h0000_07FF, "R8 address after wrap");

    // R3 R4 R7: write slot B while switching to it on the same edge
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 32'd100, 1'b0);
    tick(1'b1, 1'b1, 1'b0, 32'd7, 1'b0);
    check32(phase_out, 32'd100, "R3 slot A step");
    tick(1'b1, 1'b1, 1'b1, 32'd1000, 1'b0);
    check32(phase_out, 32'd107, "R7 switch keeps phase, old B used");
    tick(1'b0, 1'b0, 1'b1, 32'h0, 1'b0);
    check32(phase_out, 32'd1107, "R4 new B used next edge");
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    check32(phase_out, 32'd1207, "R3 back to slot A");

    // R9: reset beats a same-edge write
    tick(1'b1, 1'b0, 1'b0, 32'd5, 1'b1);
    check32(phase_out, 32'h0, "R9 phase during reset");
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    check32(phase_out, 32'h0, "R9 slot A still zero");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule